// File: doc/BRIEF.md
# Interrupt Routing Register File with Windowed Access

This block holds the programmable state of an interrupt router: a small identification register, a read-only version word, an arbitration word, and one 64-bit routing entry per interrupt pin. Software does not address these registers directly. It writes an 8-bit select value to one bus offset, and then reads or writes the chosen register through a second offset, the data window. Each 64-bit routing entry takes two select values, one for its low 32 bits and one for its high 32 bits.

The bus side is a single-cycle read/write port with an address, a byte length, 32 bits of write data and a 64-bit read result. A hit output marks addresses inside the block's 256-byte aperture. Toward the delivery logic the block exports every routing entry as one flat vector, and it raises a one-cycle strobe whenever a write flips an entry's mask bit. The delivery logic drives per-pin requests to set or clear each entry's remote-IRR flag, which the bus can read but cannot write.

Routing entry layout: vector 7:0, delivery mode 10:8, destination mode 11, polarity 13, remote IRR 14, trigger mode 15, mask 16, destination 63:56. Only the mask and remote-IRR bits have behaviour inside this block. The other fields are stored and exported as written.

Top module: `irq_route_regfile`

## Requirements
- R1: After reset every entry reads low half 0x00010000 (mask bit 16 set) and high half 0. The select register and the 4-bit identifier are 0, and the mask strobe is low.
- R2: `bus_hit` is high exactly when BASE_ADDR <= `bus_addr` < BASE_ADDR + 256. Writes while it is low change nothing, and reads while it is low return 0.
- R3: Only `bus_addr[7:0]` selects the register: offset 0x00 is the select register and offset 0x10 is the data window. Every other offset reads 0 and ignores writes. `bus_rdata` is 0 whenever `bus_rd` is low.
- R4: The select register is 8 bits wide. A write stores the low byte of the length-trimmed data, and it reads back at offset 0x00 in bits 7:0.
- R5: With select 0x00, the window reads the identifier in bits 27:24 with all other bits 0, and a write loads bits 27:24. With select 0x02, the window reads the same word, and writes are ignored.
- R6: With select 0x01, the window reads (NUM_PINS - 1) in bits 23:16 and VERSION_CODE in bits 7:0, with all other bits 0. Writes are ignored.
- R7: A select value s >= 0x10 addresses entry (s - 0x10) >> 1. An odd s reaches bits 63:32 and an even s reaches bits 31:0. A write to one half leaves the other half intact.
- R8: A select in 0x03..0x0F, or a table select whose index is NUM_PINS or more, reads 0 and drops writes.
- R9: Remote IRR (bit 14) cannot be written from the bus. A write to an entry's low half clears it, and a write to the high half leaves it unchanged.
- R10: `rirr_set[i]` sets entry i's remote IRR on the next edge and `rirr_clr[i]` clears it. A clear, or a low-half write to that entry, wins over a set in the same cycle.
- R11: One cycle after a low-half write flips an entry's mask bit, `mchg_valid` pulses for one cycle, with `mchg_pin` giving the entry index and `mchg_mask` giving the new mask. A write that keeps the mask bit unchanged gives no pulse.
- R12: `bus_len` must be 1, 2, 4 or 8. Writes use the low 8, 16, 32 or 32 data bits, and any other length makes the write a no-op. Reads return the 32-bit result trimmed the same way and zero-extended to 64 bits. Other lengths read 0.
- R13: `table_flat[64*i +: 64]` always equals entry i as read through the window, including remote IRR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Access address |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_len | input | 4 | Access length in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 64 | Read result, valid in the cycle of `bus_rd` |
| bus_hit | output | 1 | Address is inside the aperture |
| table_flat | output | 64*NUM_PINS | All routing entries, entry i at bits 64*i+63:64*i |
| mchg_valid | output | 1 | Mask-change pulse |
| mchg_pin | output | PIN_W | Entry whose mask changed |
| mchg_mask | output | 1 | New mask value |
| rirr_set | input | NUM_PINS | Per-entry remote-IRR set requests |
| rirr_clr | input | NUM_PINS | Per-entry remote-IRR clear requests |

## Verification
Random select values span the identifier, version and arbitration codes, the reserved codes 0x03..0x0F, every valid table half, and indices just past the last pin. This separates the index arithmetic from the range check and the odd/even half choice. Random window data with random lengths, including an illegal length of 3, separates the write trimming from the read trimming. Mask bits that flip and mask bits that are rewritten unchanged show whether the strobe follows a change or merely a write. Remote-IRR set and clear bursts mixed with both kinds of half write, plus directed collisions of set with clear, expose the priority between bus writes and delivery requests.

// File: rtl/irq_rf_pkg.sv
// Shared constants, entry layouts and helpers for the interrupt routing
// register file. Assumes a 32-bit window word and an 8-bit select register.
package irq_rf_pkg;

    // Bus offsets inside the 256-byte aperture.
    localparam logic [7:0] OFF_SELECT = 8'h00;
    localparam logic [7:0] OFF_WINDOW = 8'h10;

    // Select codes reached through the window.
    localparam logic [7:0] SEL_IDENT   = 8'h00;
    localparam logic [7:0] SEL_VERSION = 8'h01;
    localparam logic [7:0] SEL_ARBIT   = 8'h02;
    localparam logic [7:0] SEL_TABLE   = 8'h10;

    // Low half of a routing entry.
    typedef struct packed {
        logic [14:0] rsvd;
        logic        mask;
        logic        trig;
        logic        rirr;
        logic        pol;
        logic        busy;
        logic        dmode;
        logic [2:0]  dlv;
        logic [7:0]  vector;
    } route_lo_t;

    // High half of a routing entry.
    typedef struct packed {
        logic [7:0]  dest;
        logic [23:0] rsvd;
    } route_hi_t;

    localparam logic [31:0] LO_RESET      = 32'h0001_0000;
    localparam logic [31:0] LO_WRITE_KEEP = 32'hFFFF_BFFF;

    // Byte-length to data mask; zero marks an unsupported length.
    function automatic logic [31:0] len_mask(input logic [3:0] len);
        case (len)
            4'd1:       return 32'h0000_00FF;
            4'd2:       return 32'h0000_FFFF;
            4'd4, 4'd8: return 32'hFFFF_FFFF;
            default:    return 32'h0000_0000;
        endcase
    endfunction

endpackage

// File: rtl/irq_rf_decode.sv
// Bus decode: aperture hit, offset selection and length trimming.
// Purely combinational; assumes one access (read or write) per cycle.
module irq_rf_decode
    import irq_rf_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [3:0]        bus_len,
    input  logic [31:0]       bus_wdata,
    output logic              hit,
    output logic              sel_wr,
    output logic              win_wr,
    output logic              sel_rd,
    output logic              win_rd,
    output logic [31:0]       wdata_eff,
    output logic [31:0]       lmask
);

    localparam int DIFF_W = ADDR_W + 1;

    logic [DIFF_W-1:0] diff;
    logic              len_ok;
    logic [7:0]        off;

    // Aperture test: unsigned distance from the base below 256.
    always_comb begin
        diff = {1'b0, bus_addr} - {1'b0, BASE_ADDR};
        hit  = (diff < DIFF_W'(256));
    end

    // Offset and length decode into per-target strobes.
    always_comb begin
        off       = bus_addr[7:0];
        lmask     = len_mask(bus_len);
        len_ok    = |lmask;
        wdata_eff = bus_wdata & lmask;
        sel_wr    = bus_wr & hit & len_ok & (off == OFF_SELECT);
        win_wr    = bus_wr & hit & len_ok & (off == OFF_WINDOW);
        sel_rd    = bus_rd & hit & (off == OFF_SELECT);
        win_rd    = bus_rd & hit & (off == OFF_WINDOW);
    end

endmodule

// File: rtl/irq_rf_window.sv
// Window decode: turns the select value into a table index and half, and
// builds the 32-bit word the window returns. Combinational; assumes
// NUM_PINS <= 120 so every table select fits in 8 bits.
module irq_rf_window
    import irq_rf_pkg::*;
#(
    parameter int         NUM_PINS     = 24,
    parameter logic [7:0] VERSION_CODE = 8'h21
) (
    input  logic [7:0]            sel,
    input  logic [3:0]            ident,
    input  logic [64*NUM_PINS-1:0] table_flat,
    output logic                  tbl_valid,
    output logic                  tbl_hi,
    output logic [6:0]            tbl_idx,
    output logic [31:0]           rd_word
);

    localparam logic [6:0] NPINS7  = 7'(NUM_PINS);
    localparam logic [7:0] LASTPIN = 8'(NUM_PINS - 1);

    logic [7:0]  rel;
    logic [63:0] cur;

    // Index arithmetic and range check for table selects.
    always_comb begin
        rel       = sel - SEL_TABLE;
        tbl_idx   = rel[7:1];
        tbl_hi    = sel[0];
        tbl_valid = (sel >= SEL_TABLE) && (tbl_idx < NPINS7);
    end

    // Pick the addressed entry out of the flat table.
    always_comb begin
        cur = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (tbl_idx == 7'(i)) cur = table_flat[64*i +: 64];
        end
    end

    // Window read word by select code.
    always_comb begin
        if (tbl_valid)                               rd_word = tbl_hi ? cur[63:32] : cur[31:0];
        else if (sel == SEL_IDENT || sel == SEL_ARBIT) rd_word = {4'h0, ident, 24'h0};
        else if (sel == SEL_VERSION)                 rd_word = {8'h0, LASTPIN, 8'h0, VERSION_CODE};
        else                                         rd_word = '0;
    end

endmodule

// File: rtl/irq_rf_entry.sv
// One routing entry: two 32-bit halves, with remote IRR kept in bit 14 of
// the low half. The bus cannot write bit 14. Assumes the caller
// decodes wr_lo/wr_hi for this entry only.
module irq_rf_entry
    import irq_rf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    input  logic        rirr_set,
    input  logic        rirr_clr,
    output logic [63:0] entry,
    output logic        mask_flip
);

    route_lo_t lo_q;
    route_hi_t hi_q;
    route_lo_t lo_new;

    // Incoming low half with remote IRR forced clear.
    always_comb begin
        lo_new    = route_lo_t'(wdata & LO_WRITE_KEEP);
        mask_flip = wr_lo && (lo_new.mask != lo_q.mask);
        entry     = {hi_q, lo_q};
    end

    // Low half and remote IRR: bus write first, then clear, then set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= route_lo_t'(LO_RESET);
        end else if (wr_lo) begin
            lo_q <= lo_new;
        end else if (rirr_clr) begin
            lo_q.rirr <= 1'b0;
        end else if (rirr_set) begin
            lo_q.rirr <= 1'b1;
        end
    end

    // High half: plain register.
    always_ff @(posedge clk) begin
        if (!rst_n)     hi_q <= '0;
        else if (wr_hi) hi_q <= route_hi_t'(wdata);
    end

    a_r9_low_write_clears_rirr: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> !entry[14]);
    a_r10_clear_beats_set: assert property (@(posedge clk) disable iff (!rst_n)
        (rirr_clr && rirr_set) |=> !entry[14]);
    a_r10_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (rirr_set && !rirr_clr && !wr_lo) |=> entry[14]);
    a_r9_high_write_keeps_rirr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !wr_lo && !rirr_set && !rirr_clr) |=> $stable(entry[14]));

endmodule

// File: rtl/irq_route_regfile.sv
// Windowed register file for an interrupt router. It holds the select
// register, the identifier and one entry per pin, exports the whole table,
// and pulses a strobe when a bus write flips a mask bit. Assumes
// ADDR_W >= 9 and NUM_PINS between 2 and 120.
module irq_route_regfile
    import irq_rf_pkg::*;
#(
    parameter int                ADDR_W       = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR    = 32'hFEC0_0000,
    parameter int                NUM_PINS     = 24,
    parameter logic [7:0]        VERSION_CODE = 8'h21,
    parameter int                PIN_W        = $clog2(NUM_PINS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [3:0]              bus_len,
    input  logic [31:0]             bus_wdata,
    output logic [63:0]             bus_rdata,
    output logic                    bus_hit,
    output logic [64*NUM_PINS-1:0]  table_flat,
    output logic                    mchg_valid,
    output logic [PIN_W-1:0]        mchg_pin,
    output logic                    mchg_mask,
    input  logic [NUM_PINS-1:0]     rirr_set,
    input  logic [NUM_PINS-1:0]     rirr_clr
);

    logic              sel_wr, win_wr, sel_rd, win_rd;
    logic [31:0]       wdata_eff, lmask, rd_word, result;
    logic [7:0]        sel_q;
    logic [3:0]        id_q;
    logic              tbl_valid, tbl_hi;
    logic [6:0]        tbl_idx;
    logic [NUM_PINS-1:0] flip_vec;

    irq_rf_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_decode (
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_len   (bus_len),
        .bus_wdata (bus_wdata),
        .hit       (bus_hit),
        .sel_wr    (sel_wr),
        .win_wr    (win_wr),
        .sel_rd    (sel_rd),
        .win_rd    (win_rd),
        .wdata_eff (wdata_eff),
        .lmask     (lmask)
    );

    irq_rf_window #(.NUM_PINS(NUM_PINS), .VERSION_CODE(VERSION_CODE)) u_window (
        .sel        (sel_q),
        .ident      (id_q),
        .table_flat (table_flat),
        .tbl_valid  (tbl_valid),
        .tbl_hi     (tbl_hi),
        .tbl_idx    (tbl_idx),
        .rd_word    (rd_word)
    );

    // One entry per pin, each decoding its own half-write strobes.
    for (genvar g = 0; g < NUM_PINS; g++) begin : g_entry
        logic hit_me;
        assign hit_me = win_wr & tbl_valid & (tbl_idx == 7'(g));
        irq_rf_entry u_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_lo     (hit_me & ~tbl_hi),
            .wr_hi     (hit_me & tbl_hi),
            .wdata     (wdata_eff),
            .rirr_set  (rirr_set[g]),
            .rirr_clr  (rirr_clr[g]),
            .entry     (table_flat[64*g +: 64]),
            .mask_flip (flip_vec[g])
        );
    end

    // Select register: low byte of the trimmed write data.
    always_ff @(posedge clk) begin
        if (!rst_n)      sel_q <= '0;
        else if (sel_wr) sel_q <= wdata_eff[7:0];
    end

    // Identifier: loaded only through the window with the identifier select.
    always_ff @(posedge clk) begin
        if (!rst_n)                              id_q <= '0;
        else if (win_wr && sel_q == SEL_IDENT)   id_q <= wdata_eff[27:24];
    end

    // Mask-change strobe, registered one cycle after the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mchg_valid <= 1'b0;
            mchg_pin   <= '0;
            mchg_mask  <= 1'b0;
        end else begin
            mchg_valid <= |flip_vec;
            if (|flip_vec) begin
                mchg_pin  <= tbl_idx[PIN_W-1:0];
                mchg_mask <= wdata_eff[16];
            end
        end
    end

    // Read result: select, window or zero, trimmed to the access length.
    always_comb begin
        if (sel_rd)      result = {24'h0, sel_q};
        else if (win_rd) result = rd_word;
        else             result = '0;
        bus_rdata = {32'h0, result & lmask};
    end

    a_r4_select_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_hit && bus_addr[7:0] == OFF_SELECT && bus_len == 4'd4)
        |=> sel_q == $past(bus_wdata[7:0]));
    a_r2_outside_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_hit) |=> ($stable(sel_q) && $stable(id_q)));
    a_r5_id_only_by_ident: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel_q != SEL_IDENT) |=> $stable(id_q));
    a_r3_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> bus_rdata == '0);
    a_r11_strobe_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        mchg_valid |-> $past(bus_wr));
    a_r11_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flip_vec));

endmodule

// File: tb/test_irq_route_regfile.sv
module test_irq_route_regfile;

    localparam logic [31:0] BASE = 32'hFEC0_0000;
    localparam int          NP   = 24;
    localparam logic [7:0]  VER  = 8'h21;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [31:0]       bus_addr = '0;
    logic              bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]        bus_len = 4'd4;
    logic [31:0]       bus_wdata = '0;
    logic [63:0]       bus_rdata;
    logic              bus_hit;
    logic [64*NP-1:0]  table_flat;
    logic              mchg_valid, mchg_mask;
    logic [4:0]        mchg_pin;
    logic [NP-1:0]     rirr_set = '0, rirr_clr = '0;

    int n_cmp = 0, n_bad = 0;

    logic [31:0] m_lo [NP];
    logic [31:0] m_hi [NP];
    logic [7:0]  m_sel;
    logic [3:0]  m_id;

    irq_route_regfile #(.ADDR_W(32), .BASE_ADDR(BASE), .NUM_PINS(NP), .VERSION_CODE(VER))
    i_irq_route_regfile (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_len(bus_len), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_hit(bus_hit),
        .table_flat(table_flat), .mchg_valid(mchg_valid), .mchg_pin(mchg_pin),
        .mchg_mask(mchg_mask), .rirr_set(rirr_set), .rirr_clr(rirr_clr)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] lm(input logic [3:0] len);
        if (len == 1) return 32'hFF;
        if (len == 2) return 32'hFFFF;
        if (len == 4 || len == 8) return 32'hFFFF_FFFF;
        return 32'h0;
    endfunction

    function automatic logic in_ap(input logic [31:0] a);
        return (a >= BASE) && (a - BASE < 32'd256);
    endfunction

    function automatic logic [31:0] win_word(input logic [7:0] s);
        logic [7:0] ix;
        if (s == 8'h00 || s == 8'h02) return {4'h0, m_id, 24'h0};
        if (s == 8'h01) return {8'h0, 8'(NP - 1), 8'h0, VER};
        if (s < 8'h10) return 32'h0;
        ix = (s - 8'h10) >> 1;
        if (ix >= 8'(NP)) return 32'h0;
        return s[0] ? m_hi[ix] : m_lo[ix];
    endfunction

    function automatic logic [63:0] exp_read(input logic [31:0] a, input logic [3:0] len);
        logic [31:0] r;
        r = 32'h0;
        if (in_ap(a) && a[7:0] == 8'h00) r = {24'h0, m_sel};
        if (in_ap(a) && a[7:0] == 8'h10) r = win_word(m_sel);
        return {32'h0, r & lm(len)};
    endfunction

    // Bus write: model update before the edge, strobe check after it (R11).
    task automatic bwr(input logic [31:0] a, input logic [3:0] len, input logic [31:0] d0);
        logic [31:0] d;
        logic [7:0]  ix;
        logic        e_chg, e_val;
        logic [4:0]  e_pin;
        e_chg = 0; e_val = 0; e_pin = 0;
        d = d0 & lm(len);
        if (in_ap(a) && lm(len) != 0) begin
            if (a[7:0] == 8'h00) m_sel = d[7:0];
            else if (a[7:0] == 8'h10) begin
                if (m_sel == 8'h00) m_id = d[27:24];
                else if (m_sel >= 8'h10) begin
                    ix = (m_sel - 8'h10) >> 1;
                    if (ix < 8'(NP)) begin
                        if (m_sel[0]) m_hi[ix] = d;
                        else begin
                            e_chg = (d[16] != m_lo[ix][16]);
                            e_pin = ix[4:0];
                            e_val = d[16];
                            m_lo[ix] = d & 32'hFFFF_BFFF;
                        end
                    end
                end
            end
        end
        bus_addr = a; bus_len = len; bus_wdata = d0; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R11 strobe", {63'h0, mchg_valid}, {63'h0, e_chg});
        if (e_chg) begin
            chk("R11 pin", {59'h0, mchg_pin}, {59'h0, e_pin});
            chk("R11 mask", {63'h0, mchg_mask}, {63'h0, e_val});
        end
    endtask

    task automatic brd(input logic [31:0] a, input logic [3:0] len, input string req);
        bus_addr = a; bus_len = len; bus_rd = 1'b1;
        #1;
        chk(req, bus_rdata, exp_read(a, len));
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic prirr(input logic [NP-1:0] s, input logic [NP-1:0] c);
        rirr_set = s; rirr_clr = c;
        for (int i = 0; i < NP; i++) begin
            if (c[i]) m_lo[i][14] = 1'b0;
            else if (s[i]) m_lo[i][14] = 1'b1;
        end
        @(negedge clk);
        rirr_set = '0; rirr_clr = '0;
    endtask

    task automatic chk_table(input string req);
        for (int i = 0; i < NP; i++)
            chk(req, table_flat[64*i +: 64], {m_hi[i], m_lo[i]});
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [3:0] lens [7];
        lens = '{4'd1, 4'd2, 4'd4, 4'd8, 4'd4, 4'd4, 4'd3};
        void'($urandom(32'd7151));
        for (int i = 0; i < NP; i++) begin m_lo[i] = 32'h0001_0000; m_hi[i] = 32'h0; end
        m_sel = 8'h0; m_id = 4'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk_table("R1 reset table");
        chk("R1 strobe idle", {63'h0, mchg_valid}, 64'h0);
        brd(BASE, 4'd4, "R1 select zero");
        brd(BASE + 32'h10, 4'd4, "R1 identifier zero");

        // R2 aperture edges
        bus_addr = BASE - 1;      #1 chk("R2 below", {63'h0, bus_hit}, 64'h0);
        bus_addr = BASE;          #1 chk("R2 first", {63'h0, bus_hit}, 64'h1);
        bus_addr = BASE + 255;    #1 chk("R2 last", {63'h0, bus_hit}, 64'h1);
        bus_addr = BASE + 256;    #1 chk("R2 past", {63'h0, bus_hit}, 64'h0);
        @(negedge clk);
        bwr(BASE + 32'h100, 4'd4, 32'h0000_0033);
        brd(BASE, 4'd4, "R2 outside write ignored");
        brd(BASE + 32'h110, 4'd4, "R2 outside read zero");

        // R3 other offsets
        bwr(BASE + 32'h20, 4'd4, 32'hFFFF_FFFF);
        brd(BASE + 32'h20, 4'd4, "R3 unmapped reads zero");
        brd(BASE, 4'd4, "R3 unmapped write ignored");

        // R4 and R12 select truncation by length
        bwr(BASE, 4'd1, 32'h0000_1234);
        brd(BASE, 4'd4, "R4 low byte kept");
        chk("R4 literal", {56'h0, m_sel}, 64'h34);
        bwr(BASE, 4'd3, 32'h0000_0001);
        brd(BASE, 4'd4, "R12 bad length write ignored");

        // R6 version
        bwr(BASE, 4'd4, 32'h1);
        brd(BASE + 32'h10, 4'd4, "R6 version");
        chk("R6 literal", exp_read(BASE + 32'h10, 4'd4), 64'h0017_0021);
        bwr(BASE + 32'h10, 4'd4, 32'hFFFF_FFFF);
        brd(BASE + 32'h10, 4'd8, "R6 write ignored, R12 zero-extended");
        brd(BASE + 32'h10, 4'd2, "R12 two-byte read");
        brd(BASE + 32'h10, 4'd5, "R12 bad length read");

        // R5 identifier and arbitration
        bwr(BASE, 4'd4, 32'h0);
        bwr(BASE + 32'h10, 4'd4, 32'hA500_0000);
        brd(BASE + 32'h10, 4'd4, "R5 identifier");
        bwr(BASE, 4'd4, 32'h2);
        bwr(BASE + 32'h10, 4'd4, 32'h3300_0000);
        brd(BASE + 32'h10, 4'd4, "R5 arbitration mirrors id");

        // R8 reserved and out-of-range selects
        bwr(BASE, 4'd4, 32'h5);
        bwr(BASE + 32'h10, 4'd4, 32'hFFFF_FFFF);
        brd(BASE + 32'h10, 4'd4, "R8 reserved select");
        bwr(BASE, 4'd4, 32'h10 + 2 * NP);
        bwr(BASE + 32'h10, 4'd4, 32'h0);
        brd(BASE + 32'h10, 4'd4, "R8 index past end");
        chk_table("R8 table untouched");

        // R7 and R11 halves and mask strobe on pin 5
        bwr(BASE, 4'd4, 32'h1B);
        bwr(BASE + 32'h10, 4'd4, 32'hC300_0000);
        bwr(BASE, 4'd4, 32'h1A);
        bwr(BASE + 32'h10, 4'd4, 32'h0000_A031);
        bwr(BASE + 32'h10, 4'd4, 32'h0000_A032);
        brd(BASE + 32'h10, 4'd4, "R7 low half");
        bwr(BASE, 4'd4, 32'h1B);
        brd(BASE + 32'h10, 4'd4, "R7 high half kept");

        // R9 and R10 remote IRR on pin 5
        prirr(NP'(1) << 5, '0);
        chk("R10 set", {63'h0, table_flat[64*5 + 14]}, 64'h1);
        bwr(BASE + 32'h10, 4'd4, 32'h1111_1111);
        chk("R9 high write keeps", {63'h0, table_flat[64*5 + 14]}, 64'h1);
        bwr(BASE, 4'd4, 32'h1A);
        bwr(BASE + 32'h10, 4'd4, 32'h0000_4031);
        chk("R9 low write clears", {63'h0, table_flat[64*5 + 14]}, 64'h0);
        prirr(NP'(1) << 5, NP'(1) << 5);
        chk("R10 clear wins", {63'h0, table_flat[64*5 + 14]}, 64'h0);
        chk_table("R13 after directed");

        // Random mix against the model
        for (int it = 0; it < 600; it++) begin
            int op;
            op = int'($urandom % 8);
            case (op)
                0, 1:    bwr(BASE, lens[$urandom % 7], $urandom % 32'h48);
                2, 3, 4: bwr(BASE + 32'h10, lens[$urandom % 7], $urandom);
                5, 6:    brd(BASE + 32'h10, lens[$urandom % 7], "R7 random window read");
                default: prirr(NP'($urandom), NP'($urandom & $urandom));
            endcase
            if (it % 20 == 0) chk_table("R13 random table");
        end
        chk_table("R13 final table");
        summary();
    end

endmodule